// File: doc/BRIEF.md
# Stack and Index Address Unit

This unit produces the address side of a small 8-bit processor with a 16-bit address space. Each clock it takes one already-decoded operation. It then drives a memory address with read or write strobes, a request to write the L/M index pair, or a program-counter load. Load and store addresses come from a 16-bit immediate or from the index pair, with M as the high byte and L as the low byte. A 16-bit stack pointer lives inside the unit. Push writes at the stack pointer and then moves it down. Pop moves it up and then reads at the new value.

The conditional jump always targets the index pair, and it is taken only when its 8-bit operand is nonzero. When it is not taken, the program counter is loaded with a next-PC value supplied from outside.

All outputs are registered. Every operation's result appears on the outputs one clock after the operation is presented, and every strobe lasts exactly that one cycle. Output fields that an operation does not use are driven to zero.

Top module: `agu_top`

## Requirements
- R1: Synchronous active-high reset clears every output to zero and sets the stack pointer to 0xFFFF, so the first push after reset writes at 0xFFFF.
- R2: Operation code 1 (load) gives `mem_re`=1, and operation code 2 (store) gives `mem_we`=1 with `mem_wdata`=`src_data`. The address is `imm16` when `amode`=0 and {`reg_m`,`reg_l`} when `amode`=1, registered one cycle after the operation.
- R3: Operation code 3 (push) gives `mem_we`=1 with `mem_addr` equal to the current stack pointer and `mem_wdata`=`src_data`. The stack pointer then decrements by one.
- R4: Operation code 4 (pop) first increments the stack pointer, then gives `mem_re`=1 with `mem_addr` equal to the incremented value.
- R5: The stack pointer wraps modulo 2^16. A pop from 0xFFFF reads at 0x0000, and a push at 0x0000 leaves the pointer at 0xFFFF.
- R6: Operation code 5 (set index) gives `idx_we`=1 with `idx_l`=`imm16[7:0]` and `idx_m`=`imm16[15:8]`.
- R7: Operation code 6 (jump) with a nonzero `jmp_val` gives `pc_load`=1 and `pc_target`={`reg_m`,`reg_l`}.
- R8: Operation code 6 with `jmp_val`=0 gives `pc_load`=1 and `pc_target`=`next_pc`.
- R9: Any cycle has at most one of `mem_we`, `mem_re`, `idx_we` and `pc_load` high. Unused output fields are zero. Codes 0 and 7 drive all outputs to zero and leave the stack pointer unchanged.
- R10: `amode` has no effect on push and pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Decoded operation code |
| amode | input | 1 | Address source for load/store: 0 immediate, 1 index pair |
| imm16 | input | 16 | 16-bit immediate |
| reg_l | input | 8 | Current L register value |
| reg_m | input | 8 | Current M register value |
| jmp_val | input | 8 | Jump condition operand |
| src_data | input | 8 | Value to store or push |
| next_pc | input | 16 | Sequential next program counter |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| idx_we | output | 1 | Index pair write request |
| idx_l | output | 8 | New L value |
| idx_m | output | 8 | New M value |
| pc_load | output | 1 | Program counter load |
| pc_target | output | 16 | Program counter value to load |

## Verification
The bench starts with pops and pushes straight out of reset, so both wrap points of the stack pointer are covered. A design that decremented before writing would put the first push at 0xFFFE. A design that read before incrementing would put the first pop at 0xFFFF. Jumps use zero and nonzero operands, so a design that tested the wrong sense, or jumped to the immediate, would load the wrong target. Push and pop are run with both address modes, and reserved codes are mixed into the stream. A design whose stack pointer reacted to the mode or to a reserved code would then give a wrong address on a later stack access.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_STORE  = 3'd2,
    OP_PUSH   = 3'd3,
    OP_POP    = 3'd4,
    OP_SETIDX = 3'd5,
    OP_JUMP   = 3'd6,
    OP_RSVD   = 3'd7
  } agu_op_e;
endpackage

// File: rtl/agu_sp.sv
module agu_sp #(
  parameter int AW = 16,
  parameter logic [AW-1:0] INIT = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] sp_cur,
  output logic [AW-1:0] sp_inc
);
  logic [AW-1:0] sp_q;

  assign sp_cur = sp_q;
  assign sp_inc = sp_q + AW'(1);

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= INIT;
    else if (push) sp_q <= sp_q - AW'(1);
    else if (pop)  sp_q <= sp_inc;
  end
endmodule

// File: rtl/agu_addr_sel.sv
module agu_addr_sel #(
  parameter int AW = 16
) (
  input  logic          use_pair,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] pair,
  output logic [AW-1:0] addr
);
  always_comb addr = use_pair ? pair : imm;
endmodule

// File: rtl/agu_jump.sv
module agu_jump #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   operand,
  input  logic [2*DW-1:0] pair,
  input  logic [2*DW-1:0] seq_pc,
  output logic            taken,
  output logic [2*DW-1:0] target
);
  always_comb begin
    taken  = |operand;
    target = taken ? pair : seq_pc;
  end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op,
  input  logic              amode,
  input  logic [ADDR_W-1:0] imm16,
  input  logic [DATA_W-1:0] reg_l,
  input  logic [DATA_W-1:0] reg_m,
  input  logic [DATA_W-1:0] jmp_val,
  input  logic [DATA_W-1:0] src_data,
  input  logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              idx_we,
  output logic [DATA_W-1:0] idx_l,
  output logic [DATA_W-1:0] idx_m,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_target
);
  import agu_pkg::*;

  agu_op_e           op_e;
  logic [ADDR_W-1:0] pair, eff_addr, sp_cur, sp_inc, jmp_tgt;
  logic              do_push, do_pop, jmp_taken;

  logic [ADDR_W-1:0] n_addr, n_tgt;
  logic [DATA_W-1:0] n_wdata, n_l, n_m;
  logic              n_we, n_re, n_iw, n_pl;

  assign op_e    = agu_op_e'(op);
  assign pair    = {reg_m, reg_l};
  assign do_push = (op_e == OP_PUSH);
  assign do_pop  = (op_e == OP_POP);

  agu_sp #(.AW(ADDR_W), .INIT({ADDR_W{1'b1}})) u_sp (
    .clk(clk), .rst(rst), .push(do_push), .pop(do_pop),
    .sp_cur(sp_cur), .sp_inc(sp_inc)
  );

  agu_addr_sel #(.AW(ADDR_W)) u_sel (
    .use_pair(amode), .imm(imm16), .pair(pair), .addr(eff_addr)
  );

  agu_jump #(.DW(DATA_W)) u_jmp (
    .operand(jmp_val), .pair(pair), .seq_pc(next_pc),
    .taken(jmp_taken), .target(jmp_tgt)
  );

  always_comb begin
    n_addr  = '0;
    n_wdata = '0;
    n_l     = '0;
    n_m     = '0;
    n_tgt   = '0;
    n_we    = 1'b0;
    n_re    = 1'b0;
    n_iw    = 1'b0;
    n_pl    = 1'b0;
    unique case (op_e)
      OP_LOAD: begin
        n_addr = eff_addr;
        n_re   = 1'b1;
      end
      OP_STORE: begin
        n_addr  = eff_addr;
        n_we    = 1'b1;
        n_wdata = src_data;
      end
      OP_PUSH: begin
        n_addr  = sp_cur;
        n_we    = 1'b1;
        n_wdata = src_data;
      end
      OP_POP: begin
        n_addr = sp_inc;
        n_re   = 1'b1;
      end
      OP_SETIDX: begin
        n_iw = 1'b1;
        n_l  = imm16[DATA_W-1:0];
        n_m  = imm16[ADDR_W-1:DATA_W];
      end
      OP_JUMP: begin
        n_pl  = 1'b1;
        n_tgt = jmp_tgt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
      idx_we    <= 1'b0;
      idx_l     <= '0;
      idx_m     <= '0;
      pc_load   <= 1'b0;
      pc_target <= '0;
    end else begin
      mem_addr  <= n_addr;
      mem_we    <= n_we;
      mem_re    <= n_re;
      mem_wdata <= n_wdata;
      idx_we    <= n_iw;
      idx_l     <= n_l;
      idx_m     <= n_m;
      pc_load   <= n_pl;
      pc_target <= n_tgt;
    end
  end

  logic unused_taken;
  assign unused_taken = jmp_taken;
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op,
  input logic              amode,
  input logic [ADDR_W-1:0] imm16,
  input logic [DATA_W-1:0] reg_l,
  input logic [DATA_W-1:0] reg_m,
  input logic [DATA_W-1:0] jmp_val,
  input logic [DATA_W-1:0] src_data,
  input logic [ADDR_W-1:0] next_pc,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              idx_we,
  input logic [DATA_W-1:0] idx_l,
  input logic [DATA_W-1:0] idx_m,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_target
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!mem_we && !mem_re && !idx_we && !pc_load && mem_addr == '0));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_we, mem_re, idx_we, pc_load}) <= 1);

  a_r2_store_addr: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2) |=> (mem_we && mem_wdata == $past(src_data) &&
      mem_addr == ($past(amode) ? {$past(reg_m), $past(reg_l)} : $past(imm16))));

  a_r6_set_index: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd5) |=> (idx_we && idx_l == $past(imm16[DATA_W-1:0]) &&
      idx_m == $past(imm16[ADDR_W-1:DATA_W])));

  a_r7_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd6 && jmp_val != '0) |=> (pc_load && pc_target == {$past(reg_m), $past(reg_l)}));

  a_r8_jump_fall: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd6 && jmp_val == '0) |=> (pc_load && pc_target == $past(next_pc)));

  a_r3_push_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 3'd3 && op == 3'd3) |=>
      (mem_we && mem_addr == $past(mem_addr) - ADDR_W'(1)));

  a_r4_pop_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 3'd4 && op == 3'd4) |=>
      (mem_re && mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

bind agu_top agu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .amode(amode), .imm16(imm16),
  .reg_l(reg_l), .reg_m(reg_m), .jmp_val(jmp_val), .src_data(src_data),
  .next_pc(next_pc), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
  .mem_wdata(mem_wdata), .idx_we(idx_we), .idx_l(idx_l), .idx_m(idx_m),
  .pc_load(pc_load), .pc_target(pc_target)
);

// File: tb/sim_agu_top.sv
`timescale 1ns/1ps
module sim_agu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = '0;
  logic        amode = 1'b0;
  logic [15:0] imm16 = '0;
  logic [7:0]  reg_l = '0, reg_m = '0, jmp_val = '0, src_data = '0;
  logic [15:0] next_pc = '0;
  logic [15:0] mem_addr, pc_target;
  logic        mem_we, mem_re, idx_we, pc_load;
  logic [7:0]  mem_wdata, idx_l, idx_m;

  int checks = 0;
  int errors = 0;
  logic [15:0] msp;

  always #2 clk = ~clk;

  agu_top u0 (
    .clk(clk), .rst(rst), .op(op), .amode(amode), .imm16(imm16),
    .reg_l(reg_l), .reg_m(reg_m), .jmp_val(jmp_val), .src_data(src_data),
    .next_pc(next_pc), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .idx_we(idx_we), .idx_l(idx_l), .idx_m(idx_m),
    .pc_load(pc_load), .pc_target(pc_target)
  );

  function automatic logic [59:0] outs();
    return {mem_we, mem_re, idx_we, pc_load, mem_addr, mem_wdata, idx_l, idx_m, pc_target};
  endfunction

  // Expected output vector from the requirements; also returns the next stack pointer.
  function automatic logic [59:0] model(input logic [2:0] o, input logic [15:0] im,
      input logic [7:0] l, input logic [7:0] m, input logic [7:0] jv,
      input logic [7:0] sd, input logic [15:0] np, input logic am,
      input logic [15:0] sp, output logic [15:0] sp_n);
    logic [59:0] e;
    e = '0;
    sp_n = sp;
    case (o)
      3'd1: begin e[58] = 1'b1; e[55:40] = am ? {m, l} : im; end
      3'd2: begin e[59] = 1'b1; e[55:40] = am ? {m, l} : im; e[39:32] = sd; end
      3'd3: begin e[59] = 1'b1; e[55:40] = sp; e[39:32] = sd; sp_n = sp - 16'd1; end
      3'd4: begin sp_n = sp + 16'd1; e[58] = 1'b1; e[55:40] = sp_n; end
      3'd5: begin e[57] = 1'b1; e[31:24] = im[7:0]; e[23:16] = im[15:8]; end
      3'd6: begin e[56] = 1'b1; e[15:0] = (jv != 0) ? {m, l} : np; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic check(input logic [59:0] exp, input string req);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, outs(), exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic am, input logic [15:0] im,
      input logic [7:0] l, input logic [7:0] m, input logic [7:0] jv,
      input logic [7:0] sd, input logic [15:0] np, input string req);
    logic [59:0] e;
    logic [15:0] sn;
    op = o; amode = am; imm16 = im; reg_l = l; reg_m = m;
    jmp_val = jv; src_data = sd; next_pc = np;
    e = model(o, im, l, m, jv, sd, np, am, msp, sn);
    msp = sn;
    @(negedge clk);
    check(e, req);
  endtask

  function automatic string tag_of(input logic [2:0] o, input logic [7:0] jv);
    case (o)
      3'd1, 3'd2: return "R2";
      3'd3:       return "R3";
      3'd4:       return "R4";
      3'd5:       return "R6";
      3'd6:       return (jv != 0) ? "R7" : "R8";
      default:    return "R9";
    endcase
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    msp = 16'hFFFF;
    repeat (3) @(negedge clk);
    check('0, "R1");
    rst = 1'b0;
    // R5: pop straight after reset wraps to 0x0000
    apply(3'd4, 1'b0, 16'h1234, 8'h11, 8'h22, 8'h0, 8'h0, 16'h0, "R5");
    // R5: push at 0x0000 writes there, pointer wraps to 0xFFFF
    apply(3'd3, 1'b1, 16'h0, 8'h0, 8'h0, 8'h0, 8'hA5, 16'h0, "R5");
    apply(3'd3, 1'b0, 16'h0, 8'h0, 8'h0, 8'h0, 8'h5A, 16'h0, "R5");
    // R1: fresh reset, first push at 0xFFFF
    rst = 1'b1; op = 3'd0;
    @(negedge clk);
    msp = 16'hFFFF;
    check('0, "R1");
    rst = 1'b0;
    apply(3'd3, 1'b0, 16'h0, 8'h0, 8'h0, 8'h0, 8'h3C, 16'h0, "R1");
    // R10: mode set on stack ops, R9: reserved code does not move the pointer
    apply(3'd3, 1'b1, 16'hBEEF, 8'hEF, 8'hBE, 8'h0, 8'h77, 16'h0, "R10");
    apply(3'd7, 1'b1, 16'hFFFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 16'hFFFF, "R9");
    apply(3'd0, 1'b1, 16'hFFFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 16'hFFFF, "R9");
    apply(3'd4, 1'b1, 16'h4444, 8'h44, 8'h44, 8'h0, 8'h0, 16'h0, "R10");
    apply(3'd2, 1'b0, 16'h8001, 8'h02, 8'h40, 8'h0, 8'h99, 16'h0, "R2");
    apply(3'd1, 1'b1, 16'h8001, 8'h02, 8'h40, 8'h0, 8'h0, 16'h0, "R2");
    apply(3'd5, 1'b0, 16'hC3A7, 8'h0, 8'h0, 8'h0, 8'h0, 16'h0, "R6");
    apply(3'd6, 1'b0, 16'h1111, 8'h34, 8'h12, 8'h01, 8'h0, 16'h0200, "R7");
    apply(3'd6, 1'b0, 16'h1111, 8'h34, 8'h12, 8'h80, 8'h0, 16'h0200, "R7");
    apply(3'd6, 1'b1, 16'h1111, 8'h34, 8'h12, 8'h00, 8'h0, 16'h0201, "R8");
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] o;
      logic [7:0] jv;
      o  = 3'($urandom_range(0, 7));
      jv = ($urandom_range(0, 1) == 0) ? 8'h0 : 8'($urandom);
      apply(o, 1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), jv,
            8'($urandom), 16'($urandom), tag_of(o, jv));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule